// File: doc/BRIEF.md
# Serial output power-up sequencer

This block brings the analog front end of a serial display output out of power-down without software stepping. On a start request it picks a link-rate code, holds every power-down control asserted, and runs an exit handshake with the chip power controller that releases the pads from deep power-down. It then releases the remaining controls in a fixed order. Between steps it waits a set number of microseconds, counted on an external one-microsecond strobe.

The handshake does four things. It turns on the controller's sampling, writes a timing-select value of 10 and raises an exit request. It then looks at the pad status once every 20 microseconds. If the pads report off, sampling and the request drop and the sequence goes on. If the pads still report on after about 10 ms, the sequence stops with an error and all controls stay asserted. A sticky flag records a finished power-up, so a later start request only answers with `done`.

Top module: `lnk_pwrup_seq`

## Requirements
- R1: A synchronous reset sets `pd_ctl` to 7'h7F and `link_rate` to 8'h00, and clears `powered`, `done`, `err`, `dpd_sample`, `dpd_timsel` and `dpd_exit_req`.
- R2: A start accepted while `powered` is low loads `link_rate` with 8'h07 when `lvds_sel` is high and with 8'h06 (1.62 Gb/s) when it is low. `pd_ctl` holds 7'h7F at that point. The bit order of `pd_ctl`, from bit 6 down to bit 0, is port, PLL, bandgap, VCO, PLL capacitor, deep-power-down, calibration, and 1 means held in power-down.
- R3: On an accepted start, `dpd_sample` goes high and `dpd_timsel` becomes 10 one cycle before `dpd_exit_req` rises. The request stays high for the whole polling phase.
- R4: Pad status is sampled every 20 ticks while the request is high. The first sample that finds `pads_on` low drops the request and sampling, and then sets `pd_ctl` to 7'h7D. The request is therefore high for exactly 20 ticks per poll.
- R5: If `pads_on` is still high at the 500th poll (10000 ticks), `err` is set, the request and sampling drop, `pd_ctl` stays 7'h7F, `powered` stays low and `done` does not pulse.
- R6: `pd_ctl` holds 7'h7D for 15 ticks and then becomes 7'h6D.
- R7: `pd_ctl` holds 7'h6D for 25 ticks and then becomes 7'h41.
- R8: `pd_ctl` holds 7'h41 for 225 ticks and then becomes 7'h01. In that same cycle `powered` sets and `done` pulses for one cycle.
- R9: The calibration bit `pd_ctl[0]` is never released.
- R10: A start while `powered` is high pulses `done` one cycle later. It leaves `pd_ctl`, `link_rate` and `dpd_sample` unchanged.
- R11: A start while a sequence is running is ignored. Step timing and the single `done` pulse are not affected.
- R12: `err` clears on the next accepted start, and that retry can complete normally. `powered` never falls except on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Power-up request |
| lvds_sel | input | 1 | Selects the LVDS link-rate code |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| pads_on | input | 1 | Power controller status: pads still powered on |
| pd_ctl | output | 7 | Power-down controls (1 = held down) |
| link_rate | output | 8 | Selected link-rate code |
| dpd_sample | output | 1 | Power controller sampling enable |
| dpd_timsel | output | 7 | Power controller timing select |
| dpd_exit_req | output | 1 | Deep-power-down exit request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Handshake timeout, held until next start |
| powered | output | 1 | Sticky powered-up flag |

## Verification
`link_rate`, `dpd_sample` and `dpd_timsel` change one cycle after the edge that samples `start`, and `dpd_exit_req` rises one cycle after that. The repeat-start `done` also comes one cycle after that edge. The bench checks each of these at the falling edge where it first appears. Step delays are counted in strobes, not in cycles. A monitor on the falling edge counts each strobe against the control pattern and the request level that were present before the rising edge that used it. Strobes are spaced four cycles apart, so the cycle of extra latency at each step change never picks up a stray strobe, and the counts must match 20 per poll and 15, 25 and 225 exactly.

// File: rtl/lnk_pwrup_pkg.sv
package lnk_pwrup_pkg;

  localparam int CTL_W = 7;

  // control bit positions inside pd_ctl
  localparam int B_PORT = 6;
  localparam int B_PLL  = 5;
  localparam int B_BG   = 4;
  localparam int B_VCO  = 3;
  localparam int B_CAP  = 2;
  localparam int B_DPD  = 1;
  localparam int B_CAL  = 0;

  typedef enum logic [2:0] {SQ_IDLE, SQ_HSK, SQ_W2, SQ_W3, SQ_W4} sq_state_e;
  typedef enum logic [1:0] {HK_IDLE, HK_ARM, HK_POLL} hk_state_e;

  // control levels for steps 1..5; each step releases more than the last
  function automatic logic [CTL_W-1:0] step_pattern(input logic [2:0] step);
    logic [CTL_W-1:0] v;
    v = '1;
    if (step >= 3'd2) v[B_DPD] = 1'b0;
    if (step >= 3'd3) v[B_BG] = 1'b0;
    if (step >= 3'd4) begin
      v[B_PLL] = 1'b0;
      v[B_VCO] = 1'b0;
      v[B_CAP] = 1'b0;
    end
    if (step >= 3'd5) v[B_PORT] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] rate_select(input logic lvds,
                                             input logic [7:0] lvds_code,
                                             input logic [7:0] low_code);
    return lvds ? lvds_code : low_code;
  endfunction

endpackage

// File: rtl/pus_tick_timer.sv
module pus_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pus_dpd_handshake.sv
module pus_dpd_handshake
  import lnk_pwrup_pkg::*;
#(
  parameter int POLL_US  = 20,
  parameter int LIMIT_US = 10000,
  parameter int TSEL_W   = 7,
  parameter int TSEL_VAL = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic              pads_on,
  output logic              sample_en,
  output logic [TSEL_W-1:0] timsel,
  output logic              exit_req,
  output logic              ok,
  output logic              fail
);
  localparam int POLLS = LIMIT_US / POLL_US;
  localparam int PC_W  = $clog2(POLLS + 1);
  localparam int PT_W  = $clog2(POLL_US + 1);

  hk_state_e       st;
  logic [PC_W-1:0] polls;
  logic            pt_load;
  logic            pt_expired;
  logic            poll_due;

  assign poll_due = (st == HK_POLL) && pt_expired;
  assign pt_load  = (st == HK_ARM) || (poll_due && pads_on);

  pus_tick_timer #(.W(PT_W)) u_poll_tmr (
    .clk(clk), .rst(rst), .load(pt_load),
    .load_val(PT_W'(POLL_US)), .tick(tick), .expired(pt_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HK_IDLE;
      polls     <= '0;
      sample_en <= 1'b0;
      timsel    <= '0;
      exit_req  <= 1'b0;
      ok        <= 1'b0;
      fail      <= 1'b0;
    end else begin
      ok   <= 1'b0;
      fail <= 1'b0;
      unique case (st)
        HK_IDLE: if (go) begin
          sample_en <= 1'b1;
          timsel    <= TSEL_W'(TSEL_VAL);
          st        <= HK_ARM;
        end
        HK_ARM: begin
          exit_req <= 1'b1;
          polls    <= '0;
          st       <= HK_POLL;
        end
        HK_POLL: if (poll_due) begin
          if (!pads_on) begin
            ok        <= 1'b1;
            exit_req  <= 1'b0;
            sample_en <= 1'b0;
            st        <= HK_IDLE;
          end else if (polls == PC_W'(POLLS - 1)) begin
            fail      <= 1'b1;
            exit_req  <= 1'b0;
            sample_en <= 1'b0;
            st        <= HK_IDLE;
          end else begin
            polls <= polls + 1'b1;
          end
        end
        default: st <= HK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_pwrup_seq.sv
module lnk_pwrup_seq
  import lnk_pwrup_pkg::*;
#(
  parameter int WAIT2_US   = 15,
  parameter int WAIT3_US   = 25,
  parameter int WAIT4_US   = 225,
  parameter int POLL_US    = 20,
  parameter int LIMIT_US   = 10000,
  parameter int TSEL_W     = 7,
  parameter int TSEL_VAL   = 10,
  parameter logic [7:0] RATE_LVDS = 8'h07,
  parameter logic [7:0] RATE_LOW  = 8'h06
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lvds_sel,
  input  logic              us_tick,
  input  logic              pads_on,
  output logic [6:0]        pd_ctl,
  output logic [7:0]        link_rate,
  output logic              dpd_sample,
  output logic [TSEL_W-1:0] dpd_timsel,
  output logic              dpd_exit_req,
  output logic              done,
  output logic              err,
  output logic              powered
);
  localparam int MAX23 = (WAIT2_US > WAIT3_US) ? WAIT2_US : WAIT3_US;
  localparam int MAXD  = (MAX23 > WAIT4_US) ? MAX23 : WAIT4_US;
  localparam int DW    = $clog2(MAXD + 1);

  sq_state_e     state;
  logic          hs_go;
  logic          hs_ok;
  logic          hs_fail;
  logic          seq_tmr_load;
  logic [DW-1:0] seq_tmr_val;
  logic          seq_tmr_done;

  assign hs_go = (state == SQ_IDLE) && start && !powered;

  always_comb begin
    seq_tmr_load = 1'b0;
    seq_tmr_val  = '0;
    unique case (state)
      SQ_HSK: if (hs_ok)        begin seq_tmr_load = 1'b1; seq_tmr_val = DW'(WAIT2_US); end
      SQ_W2:  if (seq_tmr_done) begin seq_tmr_load = 1'b1; seq_tmr_val = DW'(WAIT3_US); end
      SQ_W3:  if (seq_tmr_done) begin seq_tmr_load = 1'b1; seq_tmr_val = DW'(WAIT4_US); end
      default: ;
    endcase
  end

  pus_tick_timer #(.W(DW)) u_step_tmr (
    .clk(clk), .rst(rst), .load(seq_tmr_load), .load_val(seq_tmr_val),
    .tick(us_tick), .expired(seq_tmr_done)
  );

  pus_dpd_handshake #(
    .POLL_US(POLL_US), .LIMIT_US(LIMIT_US), .TSEL_W(TSEL_W), .TSEL_VAL(TSEL_VAL)
  ) u_hs (
    .clk(clk), .rst(rst), .go(hs_go), .tick(us_tick), .pads_on(pads_on),
    .sample_en(dpd_sample), .timsel(dpd_timsel), .exit_req(dpd_exit_req),
    .ok(hs_ok), .fail(hs_fail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      pd_ctl    <= step_pattern(3'd1);
      link_rate <= 8'h00;
      done      <= 1'b0;
      err       <= 1'b0;
      powered   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          if (powered) begin
            done <= 1'b1;
          end else begin
            link_rate <= rate_select(lvds_sel, RATE_LVDS, RATE_LOW);
            pd_ctl    <= step_pattern(3'd1);
            err       <= 1'b0;
            state     <= SQ_HSK;
          end
        end
        SQ_HSK: begin
          if (hs_ok) begin
            pd_ctl <= step_pattern(3'd2);
            state  <= SQ_W2;
          end else if (hs_fail) begin
            err   <= 1'b1;
            state <= SQ_IDLE;
          end
        end
        SQ_W2: if (seq_tmr_done) begin
          pd_ctl <= step_pattern(3'd3);
          state  <= SQ_W3;
        end
        SQ_W3: if (seq_tmr_done) begin
          pd_ctl <= step_pattern(3'd4);
          state  <= SQ_W4;
        end
        SQ_W4: if (seq_tmr_done) begin
          pd_ctl  <= step_pattern(3'd5);
          powered <= 1'b1;
          done    <= 1'b1;
          state   <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_pwrup_chk.sv
module lnk_pwrup_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] pd_ctl,
  input logic       dpd_sample,
  input logic       dpd_exit_req,
  input logic       done,
  input logic       err,
  input logic       powered,
  input logic       hs_ok,
  input logic       hs_fail
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pd_ctl == 7'h7F && !powered && !done && !err && !dpd_exit_req));

  a_r3_req_with_sample: assert property (@(posedge clk) disable iff (rst)
    dpd_exit_req |-> dpd_sample);

  a_r4_ok_releases_dpd: assert property (@(posedge clk) disable iff (rst)
    hs_ok |=> (pd_ctl == 7'h7D));

  a_r5_fail_holds_step1: assert property (@(posedge clk) disable iff (rst)
    hs_fail |=> (err && pd_ctl == 7'h7F && !powered && !done));

  a_r7_order_step3: assert property (@(posedge clk) disable iff (rst)
    (pd_ctl == 7'h41 && $past(pd_ctl) != 7'h41) |-> ($past(pd_ctl) == 7'h6D));

  a_r8_done_when_up: assert property (@(posedge clk) disable iff (rst)
    done |-> (powered && pd_ctl == 7'h01 && !err));

  a_r9_cal_kept: assert property (@(posedge clk) disable iff (rst)
    pd_ctl[0]);

  a_r12_powered_sticky: assert property (@(posedge clk) disable iff (rst)
    powered |=> powered);
endmodule

bind lnk_pwrup_seq lnk_pwrup_chk u_chk (
  .clk(clk), .rst(rst), .pd_ctl(pd_ctl), .dpd_sample(dpd_sample),
  .dpd_exit_req(dpd_exit_req), .done(done), .err(err), .powered(powered),
  .hs_ok(hs_ok), .hs_fail(hs_fail)
);

// File: tb/lnk_pwrup_seq_bench.sv
module lnk_pwrup_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic lvds_sel = 1'b0;
  logic us_tick = 1'b0;
  logic pads_on = 1'b1;
  logic [6:0] pd_ctl;
  logic [7:0] link_rate;
  logic       dpd_sample;
  logic [6:0] dpd_timsel;
  logic       dpd_exit_req;
  logic       done;
  logic       err;
  logic       powered;

  always #4 clk = ~clk;

  lnk_pwrup_seq u_lnk_pwrup_seq (
    .clk(clk), .rst(rst), .start(start), .lvds_sel(lvds_sel), .us_tick(us_tick),
    .pads_on(pads_on), .pd_ctl(pd_ctl), .link_rate(link_rate),
    .dpd_sample(dpd_sample), .dpd_timsel(dpd_timsel), .dpd_exit_req(dpd_exit_req),
    .done(done), .err(err), .powered(powered)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // monitor state
  int req_ticks, w2_ticks, w3_ticks, w4_ticks, done_cnt;
  int rel_n = 1;
  logic [6:0] prev_ctl = 7'h7F;
  logic prev_req = 1'b0;
  int div = 0;

  // expected control patterns, written out per step
  localparam logic [6:0] E1 = 7'b1111111;
  localparam logic [6:0] E2 = 7'b1111101;
  localparam logic [6:0] E3 = 7'b1101101;
  localparam logic [6:0] E4 = 7'b1000001;
  localparam logic [6:0] E5 = 7'b0000001;

  // {lvds_sel, polls before pads report off}
  localparam logic [10:0] VEC [4] = '{
    {1'b0, 10'd1}, {1'b1, 10'd2}, {1'b0, 10'd5}, {1'b1, 10'd1}
  };

  always @(negedge clk) begin
    cycles++;
    if (us_tick) begin
      if (prev_req) req_ticks++;
      if (prev_ctl == E2) w2_ticks++;
      if (prev_ctl == E3) w3_ticks++;
      if (prev_ctl == E4) w4_ticks++;
    end
    if (done) done_cnt++;
    prev_ctl = pd_ctl;
    prev_req = dpd_exit_req;
    pads_on  = !(rel_n != 0 && req_ticks >= 20 * rel_n);
    div      = (div + 1) % 4;
    us_tick  = (div == 3);
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp_v);
    compared++;
    if (act !== exp_v) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp_v);
    end
  endtask

  task automatic clear_mon();
    req_ticks = 0; w2_ticks = 0; w3_ticks = 0; w4_ticks = 0; done_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ctl", pd_ctl, E1);
    chk("R1 rate", link_rate, 8'h00);
    chk("R1 flags", {powered, done, err, dpd_sample, dpd_exit_req}, 5'b0);
    chk("R1 timsel", dpd_timsel, 7'd0);
  endtask

  // start a sequence and wait for done or err
  task automatic run_seq(input logic lv, input int polls, input logic poke);
    logic poked;
    poked = 1'b0;
    @(negedge clk);
    clear_mon();
    rel_n = polls;
    lvds_sel = lv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 rate", link_rate, lv ? 8'h07 : 8'h06);
    chk("R2 ctl at start", pd_ctl, E1);
    chk("R3 sample/timsel before req", {dpd_sample, dpd_timsel, dpd_exit_req}, {1'b1, 7'd10, 1'b0});
    chk("R12 err cleared on start", err, 1'b0);
    @(negedge clk);
    chk("R3 req raised", {dpd_exit_req, dpd_sample}, 2'b11);
    for (int i = 0; i < 60000; i++) begin
      if (done_cnt != 0 || err) break;
      if (poke && !poked && pd_ctl == E3) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        poked = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_ok(input int polls);
    chk("R4 req ticks", req_ticks, 20 * polls);
    chk("R6 step2 ticks", w2_ticks, 15);
    chk("R7 step3 ticks", w3_ticks, 25);
    chk("R8 step4 ticks", w4_ticks, 225);
    chk("R8 final ctl", pd_ctl, E5);
    chk("R8 powered/done", {powered, done_cnt[3:0]}, {1'b1, 4'd1});
    chk("R4 req/sample low", {dpd_exit_req, dpd_sample, err}, 3'b0);
    chk("R9 cal held", pd_ctl[0], 1'b1);
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected <190000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // table walk: each vector is a fresh power-up
    for (int v = 0; v < 4; v++) begin
      do_reset();
      run_seq(VEC[v][10], int'(VEC[v][9:0]), 1'b0);
      check_ok(int'(VEC[v][9:0]));
    end

    // R10: repeat start after power-up answers at once
    @(negedge clk);
    clear_mon();
    lvds_sel = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done next cycle", done, 1'b1);
    chk("R10 no handshake", {dpd_sample, dpd_exit_req}, 2'b00);
    chk("R10 ctl unchanged", pd_ctl, E5);
    chk("R10 rate unchanged", link_rate, 8'h07);
    @(negedge clk);
    chk("R10 done single", done, 1'b0);

    // R11: start during a running sequence
    do_reset();
    run_seq(1'b0, 3, 1'b1);
    chk("R11 step3 ticks with extra start", w3_ticks, 25);
    chk("R11 single done", done_cnt, 1);
    chk("R11 ticks of later steps", {w2_ticks[7:0], w4_ticks[7:0]}, {8'd15, 8'd225});

    // R5: pads never report off
    do_reset();
    run_seq(1'b1, 0, 1'b0);
    chk("R5 err", err, 1'b1);
    chk("R5 ticks to timeout", req_ticks, 10000);
    chk("R5 ctl held", pd_ctl, E1);
    chk("R5 not powered, no done", {powered, done_cnt[3:0]}, 5'b0);
    chk("R5 req/sample dropped", {dpd_exit_req, dpd_sample}, 2'b00);

    // R12: retry after the error
    run_seq(1'b0, 1, 1'b0);
    check_ok(1);
    chk("R12 retry rate", link_rate, 8'h06);

    // R1 again: reset clears the sticky flag
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule